// File: doc/BRIEF.md
# Shared Bus Priority Arbiter with Starvation Guard

This block decides which of several masters owns a shared peripheral bus. Each master raises a request line and is given a small priority number through a configuration input. One priority level is named as the round-robin level. Masters at that level take turns, and all other levels are served strictly by number. A per-master counter of lost arbitration rounds lets a waiting request overtake every priority once it reaches a programmable limit. This guard is always active and cannot be turned off.

The grant is registered and one-hot. The block also follows the bus pipeline. A granted master that is still requesting moves into the address stage, and the address stage moves into the data stage. Both moves happen on every cycle without wait states, so the next owner is chosen while the current data phase completes. A master holding its lock line keeps the bus across a multi-phase atomic or block transfer. Slave wait states freeze the grant, the counters and the pipeline. When nobody requests, the grant parks on the last owner.

Top module: `pbus_arb`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first arbitration, `gnt_o` is all zeros and `aph_vld_o` and `dph_vld_o` are low. The round-robin pointer starts at master N-1, so master 0 is searched first.
- R2: An arbitration cycle is a clock edge with `ready_i` high, at least one request, and no lock held by the current owner. Its result appears in `gnt_o` and `gnt_id_o` from that edge on. `gnt_o` is always zero or one-hot, and an arbitration only grants a master that requested at that edge.
- R3: If no request is starved, the requesting master with the numerically largest priority wins. Among several such masters at a level other than `rr_level_i`, the lowest index wins.
- R4: When the top requesting level equals `rr_level_i`, the winner is the first requesting member of that level found by scanning upward and cyclically from the member granted last.
- R5: The round-robin pointer moves only when a master whose priority equals `rr_level_i` is granted. Grants to other levels leave it unchanged.
- R6: Each master's counter is cleared while its request is low and when it wins. It increments by one on each arbitration cycle in which it requests and loses. It saturates at 2^CNT_W-1 and holds on all other cycles.
- R7: A requesting master whose counter is at least `starve_lim_i` is starved. Any starved master beats all priorities, and among several starved masters the lowest index wins.
- R8: A cycle with `ready_i` high and no request leaves `gnt_o` unchanged (bus parking).
- R9: While `ready_i` is low, `gnt_o`, the counters, the round-robin pointer and both pipeline stages hold their values.
- R10: While the current owner holds its `lock_i` bit high, no arbitration takes place. The grant stays with the owner and the counters hold.
- R11: On each edge with `ready_i` high, the address stage becomes valid with the current owner's index if that owner is requesting, and becomes invalid otherwise. On the same edge the data stage takes the previous address stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MST | Bus request per master |
| lock_i | input | N_MST | Owner keeps the bus for a multi-phase transfer |
| prio_i | input | N_MST*PRIO_W | Priority per master, master i at bits [i*PRIO_W +: PRIO_W], larger is more urgent |
| rr_level_i | input | PRIO_W | Priority level that forms the round-robin group |
| starve_lim_i | input | CNT_W | Lost-round count at which a request is starved |
| ready_i | input | 1 | High when the slave inserts no wait state |
| gnt_o | output | N_MST | One-hot grant |
| gnt_id_o | output | $clog2(N_MST) | Index of the granted master |
| aph_vld_o | output | 1 | Address stage holds a transfer |
| aph_id_o | output | $clog2(N_MST) | Master in the address stage |
| dph_vld_o | output | 1 | Data stage holds a transfer |
| dph_id_o | output | $clog2(N_MST) | Master in the data stage |

## Verification
Directed sequences isolate single rules, each with a stimulus that exposes one mistake:
- A full request vector against distinct priorities, then a tie at a fixed level, separate strict ordering from index order.
- Five rounds with everyone at the group level show the cyclic turn-taking.
- A grant to a higher fixed level followed by a group grant tells a correct pointer from one that moved.
- Two-master and three-master patterns under small limits show a starved low-priority request overtaking, and the lowest starved index winning over a higher-priority starved peer.
- Wait states, lock and an idle cycle confirm hold and parking, and a lone request traced through both stages confirms the pipeline timing.

A pseudo-random sweep over eight configurations then compares grant and both stages every cycle against an arithmetic model. The configurations include limits of zero and of the saturation value, with random wait states and locks.

// File: rtl/pbus_arb_pkg.sv
package pbus_arb_pkg;
  typedef enum logic [1:0] {
    WIN_NONE   = 2'd0,
    WIN_STARVE = 2'd1,
    WIN_PRIO   = 2'd2,
    WIN_RING   = 2'd3
  } win_src_e;
endpackage

// File: rtl/pbus_starve_cnt.sv
module pbus_starve_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             arb_i,
  input  logic             won_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic             starved_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!req_i)   cnt_q <= '0;
    else if (arb_i) begin
      if (won_i)                cnt_q <= '0;
      else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign starved_o = req_i && (cnt_q >= lim_i);

  assert_cnt_win_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arb_i && won_i) |=> (cnt_q == '0));
  assert_cnt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !arb_i) |=> (cnt_q == $past(cnt_q) || cnt_q == '0));
endmodule

// File: rtl/pbus_arb_select.sv
module pbus_arb_select
  import pbus_arb_pkg::*;
#(
  parameter int N_MST  = 8,
  parameter int PRIO_W = 3,
  localparam int IDW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       rr_level_i,
  input  logic [N_MST-1:0]        starved_i,
  input  logic [IDW-1:0]          ptr_i,
  output logic                    win_vld_o,
  output logic [IDW-1:0]          win_idx_o,
  output logic                    win_ring_o,
  output win_src_e                win_src_o
);
  logic [PRIO_W-1:0] top_p;
  logic              any_req;
  logic              st_hit;
  logic [IDW-1:0]    st_idx;
  logic [IDW-1:0]    fix_idx;
  logic              ring_hit;
  logic [IDW-1:0]    ring_idx;

  // highest requesting level
  always_comb begin
    top_p   = '0;
    any_req = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      if (req_i[i] && (!any_req || prio_i[i*PRIO_W +: PRIO_W] > top_p)) begin
        top_p   = prio_i[i*PRIO_W +: PRIO_W];
        any_req = 1'b1;
      end
    end
  end

  // lowest index among starved, lowest index at top level
  always_comb begin
    st_hit  = 1'b0;
    st_idx  = '0;
    fix_idx = '0;
    for (int i = N_MST - 1; i >= 0; i--) begin
      if (starved_i[i]) begin
        st_hit = 1'b1;
        st_idx = IDW'(i);
      end
      if (req_i[i] && prio_i[i*PRIO_W +: PRIO_W] == top_p) fix_idx = IDW'(i);
    end
  end

  // cyclic scan after pointer; smallest distance assigned last
  always_comb begin
    ring_hit = 1'b0;
    ring_idx = '0;
    for (int k = N_MST; k >= 1; k--) begin
      if (req_i[(int'(ptr_i) + k) % N_MST] &&
          prio_i[((int'(ptr_i) + k) % N_MST)*PRIO_W +: PRIO_W] == rr_level_i) begin
        ring_hit = 1'b1;
        ring_idx = IDW'((int'(ptr_i) + k) % N_MST);
      end
    end
  end

  always_comb begin
    win_vld_o = 1'b1;
    if (st_hit) begin
      win_idx_o = st_idx;
      win_src_o = WIN_STARVE;
    end else if (any_req && top_p == rr_level_i && ring_hit) begin
      win_idx_o = ring_idx;
      win_src_o = WIN_RING;
    end else if (any_req) begin
      win_idx_o = fix_idx;
      win_src_o = WIN_PRIO;
    end else begin
      win_vld_o = 1'b0;
      win_idx_o = '0;
      win_src_o = WIN_NONE;
    end
    win_ring_o = win_vld_o && (prio_i[win_idx_o*PRIO_W +: PRIO_W] == rr_level_i);
  end

  always_comb begin
    if (win_vld_o) assert_win_requests_R2: assert (req_i[win_idx_o]);
    if (win_src_o == WIN_PRIO) assert_prio_top_R3: assert (prio_i[win_idx_o*PRIO_W +: PRIO_W] == top_p);
  end
endmodule

// File: rtl/pbus_phase_pipe.sv
module pbus_phase_pipe #(
  parameter int IDW = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ready_i,
  input  logic           own_act_i,
  input  logic [IDW-1:0] own_id_i,
  output logic           aph_vld_o,
  output logic [IDW-1:0] aph_id_o,
  output logic           dph_vld_o,
  output logic [IDW-1:0] dph_id_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aph_vld_o <= 1'b0;
      aph_id_o  <= '0;
      dph_vld_o <= 1'b0;
      dph_id_o  <= '0;
    end else if (ready_i) begin
      dph_vld_o <= aph_vld_o;
      dph_id_o  <= aph_id_o;
      aph_vld_o <= own_act_i;
      aph_id_o  <= own_id_i;
    end
  end

  assert_dph_follows_aph_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_i |=> (dph_vld_o == $past(aph_vld_o)));
  assert_pipe_wait_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> ($stable(aph_vld_o) && $stable(dph_vld_o) && $stable(dph_id_o)));
endmodule

// File: rtl/pbus_arb.sv
module pbus_arb
  import pbus_arb_pkg::*;
#(
  parameter int N_MST  = 8,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 8,
  localparam int IDW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MST-1:0]        req_i,
  input  logic [N_MST-1:0]        lock_i,
  input  logic [N_MST*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       rr_level_i,
  input  logic [CNT_W-1:0]        starve_lim_i,
  input  logic                    ready_i,
  output logic [N_MST-1:0]        gnt_o,
  output logic [IDW-1:0]          gnt_id_o,
  output logic                    aph_vld_o,
  output logic [IDW-1:0]          aph_id_o,
  output logic                    dph_vld_o,
  output logic [IDW-1:0]          dph_id_o
);
  logic [N_MST-1:0] gnt_q;
  logic [IDW-1:0]   gnt_id_q;
  logic [IDW-1:0]   ptr_q;
  logic [N_MST-1:0] starved;
  logic [N_MST-1:0] won;
  logic             locked;
  logic             arb;
  logic             win_vld;
  logic [IDW-1:0]   win_idx;
  logic             win_ring;
  win_src_e         win_src;

  assign locked = |(gnt_q & lock_i);
  assign arb    = ready_i && !locked && win_vld;
  assign won    = arb ? (N_MST'(1) << win_idx) : '0;

  for (genvar g = 0; g < N_MST; g++) begin : g_cnt
    pbus_starve_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_i     (req_i[g]),
      .arb_i     (arb),
      .won_i     (won[g]),
      .lim_i     (starve_lim_i),
      .starved_o (starved[g])
    );
  end

  pbus_arb_select #(.N_MST(N_MST), .PRIO_W(PRIO_W)) u_sel (
    .req_i      (req_i),
    .prio_i     (prio_i),
    .rr_level_i (rr_level_i),
    .starved_i  (starved),
    .ptr_i      (ptr_q),
    .win_vld_o  (win_vld),
    .win_idx_o  (win_idx),
    .win_ring_o (win_ring),
    .win_src_o  (win_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q    <= '0;
      gnt_id_q <= '0;
      ptr_q    <= IDW'(N_MST - 1);
    end else if (arb) begin
      gnt_q    <= N_MST'(1) << win_idx;
      gnt_id_q <= win_idx;
      if (win_ring) ptr_q <= win_idx;
    end
  end

  pbus_phase_pipe #(.IDW(IDW)) u_pipe (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ready_i   (ready_i),
    .own_act_i (|(gnt_q & req_i)),
    .own_id_i  (gnt_id_q),
    .aph_vld_o (aph_vld_o),
    .aph_id_o  (aph_id_o),
    .dph_vld_o (dph_vld_o),
    .dph_id_o  (dph_id_o)
  );

  assign gnt_o    = gnt_q;
  assign gnt_id_o = gnt_id_q;

  assert_gnt_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  assert_gnt_to_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !locked && |req_i) |=> |(gnt_o & $past(req_i)));
  assert_starve_wins_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && !locked && |starved) |=> starved_rise_ok(gnt_o, $past(starved)));
  assert_park_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && req_i == '0) |=> $stable(gnt_o));
  assert_wait_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |=> ($stable(gnt_o) && $stable(ptr_q)));
  assert_lock_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && locked) |=> $stable(gnt_o));
  assert_ptr_ring_only_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arb && win_src == WIN_RING) && !(arb && win_ring) |=> $stable(ptr_q));

  // grant must land on the lowest set bit of the starved vector
  function automatic logic starved_rise_ok(logic [N_MST-1:0] g, logic [N_MST-1:0] s);
    return g == (s & (~s + 1'b1));
  endfunction
endmodule

// File: tb/pbus_arb_tb_top.sv
`timescale 1ns/1ps
module pbus_arb_tb_top;
  localparam int N   = 4;
  localparam int PW  = 2;
  localparam int CW  = 4;
  localparam int IDW = 2;
  localparam int CMAX = 15;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [N-1:0]    req_i = '0;
  logic [N-1:0]    lock_i = '0;
  logic [N*PW-1:0] prio_i = '0;
  logic [PW-1:0]   rr_level_i = '0;
  logic [CW-1:0]   starve_lim_i = '1;
  logic            ready_i = 1'b1;
  logic [N-1:0]    gnt_o;
  logic [IDW-1:0]  gnt_id_o;
  logic            aph_vld_o, dph_vld_o;
  logic [IDW-1:0]  aph_id_o, dph_id_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference state
  int m_cnt [N];
  bit m_gv;
  int m_gid;
  int m_ptr;
  bit m_av, m_dv;
  int m_aid, m_did;

  always #4 clk_i = ~clk_i;

  pbus_arb #(.N_MST(N), .PRIO_W(PW), .CNT_W(CW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .lock_i(lock_i),
    .prio_i(prio_i), .rr_level_i(rr_level_i), .starve_lim_i(starve_lim_i),
    .ready_i(ready_i), .gnt_o(gnt_o), .gnt_id_o(gnt_id_o),
    .aph_vld_o(aph_vld_o), .aph_id_o(aph_id_o),
    .dph_vld_o(dph_vld_o), .dph_id_o(dph_id_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int pr(int i);
    return int'(prio_i[i*PW +: PW]);
  endfunction

  function automatic int ref_winner(logic [N-1:0] r);
    int best;
    for (int i = 0; i < N; i++)
      if (r[i] && m_cnt[i] >= int'(starve_lim_i)) return i;
    best = -1;
    for (int i = 0; i < N; i++)
      if (r[i] && (best < 0 || pr(i) > pr(best))) best = i;
    if (best >= 0 && pr(best) == int'(rr_level_i))
      for (int k = 1; k <= N; k++)
        if (r[(m_ptr + k) % N] && pr((m_ptr + k) % N) == int'(rr_level_i)) return (m_ptr + k) % N;
    return best;
  endfunction

  task automatic set_cfg(int p0, int p1, int p2, int p3, int rr, int lim);
    prio_i = {PW'(p3), PW'(p2), PW'(p1), PW'(p0)};
    rr_level_i = PW'(rr);
    starve_lim_i = CW'(lim);
  endtask

  task automatic cyc(logic [N-1:0] r, logic [N-1:0] l, bit rdy);
    int w;
    bit nv;
    int nid;
    req_i = r; lock_i = l; ready_i = rdy;
    @(posedge clk_i);
    if (rdy) begin
      nv = m_gv && r[m_gid];
      nid = m_gid;
      m_dv = m_av; m_did = m_aid;
      m_av = nv;   m_aid = nid;
      if (!(m_gv && l[m_gid]) && r != '0) begin
        w = ref_winner(r);
        for (int i = 0; i < N; i++)
          if (r[i]) m_cnt[i] = (i == w) ? 0 : ((m_cnt[i] < CMAX) ? m_cnt[i] + 1 : CMAX);
        m_gv = 1'b1;
        m_gid = w;
        if (pr(w) == int'(rr_level_i)) m_ptr = w;
      end
    end
    for (int i = 0; i < N; i++) if (!r[i]) m_cnt[i] = 0;
    @(negedge clk_i);
    chk("R2 model grant", int'(gnt_o), m_gv ? (1 << m_gid) : 0);
    chk("R11 model aph valid", int'(aph_vld_o), int'(m_av));
    chk("R11 model dph valid", int'(dph_vld_o), int'(m_dv));
    if (m_av) chk("R11 model aph id", int'(aph_id_o), m_aid);
    if (m_dv) chk("R11 model dph id", int'(dph_id_o), m_did);
  endtask

  task automatic gnt_is(string tag, int idx);
    chk(tag, int'(gnt_o), 1 << idx);
  endtask

  initial begin
    #1_600_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run completion)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    logic [N-1:0] sv_a;
    int sv_ai;
    for (int i = 0; i < N; i++) m_cnt[i] = 0;
    m_gv = 0; m_gid = 0; m_ptr = N - 1;
    m_av = 0; m_dv = 0; m_aid = 0; m_did = 0;

    repeat (3) @(negedge clk_i);
    chk("R1 gnt in reset", int'(gnt_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 gnt after reset", int'(gnt_o), 0);
    chk("R1 aph after reset", int'(aph_vld_o), 0);
    chk("R1 dph after reset", int'(dph_vld_o), 0);

    // R3 strict order and tie
    set_cfg(1, 3, 2, 0, 0, 15);
    cyc(4'b1111, 4'b0000, 1); gnt_is("R3 top priority", 1);
    set_cfg(2, 2, 2, 1, 0, 15);
    cyc(4'b0110, 4'b0000, 1); gnt_is("R3 tie lowest index", 1);

    // R4 ring from reset pointer
    set_cfg(1, 1, 1, 1, 1, 15);
    cyc(4'b1111, 4'b0000, 1); gnt_is("R4 ring turn 0", 0);
    cyc(4'b1111, 4'b0000, 1); gnt_is("R4 ring turn 1", 1);
    cyc(4'b1111, 4'b0000, 1); gnt_is("R4 ring turn 2", 2);
    cyc(4'b1111, 4'b0000, 1); gnt_is("R4 ring turn 3", 3);
    cyc(4'b1111, 4'b0000, 1); gnt_is("R4 ring wrap", 0);

    // R5 pointer untouched by non-group grant
    set_cfg(1, 1, 3, 1, 1, 15);
    cyc(4'b1111, 4'b0000, 1); gnt_is("R5 fixed level wins", 2);
    cyc(4'b1011, 4'b0000, 1); gnt_is("R5 pointer kept", 1);

    // R8 parking
    cyc(4'b0000, 4'b0000, 1); gnt_is("R8 parked", 1);

    // R6 and R7 starvation of one low request
    set_cfg(0, 3, 0, 0, 2, 3);
    cyc(4'b0011, 4'b0000, 1); gnt_is("R6 loss 1", 1);
    cyc(4'b0011, 4'b0000, 1); gnt_is("R6 loss 2", 1);
    cyc(4'b0011, 4'b0000, 1); gnt_is("R6 loss 3", 1);
    cyc(4'b0011, 4'b0000, 1); gnt_is("R7 starved low wins", 0);
    cyc(4'b0011, 4'b0000, 1); gnt_is("R6 cleared on win", 1);

    // R7 lowest starved index beats higher-priority starved
    cyc(4'b0000, 4'b0000, 1);
    set_cfg(0, 0, 1, 3, 2, 2);
    cyc(4'b1110, 4'b0000, 1); gnt_is("R7 top first", 3);
    cyc(4'b1110, 4'b0000, 1); gnt_is("R7 top second", 3);
    cyc(4'b1110, 4'b0000, 1); gnt_is("R7 lowest starved", 1);
    cyc(4'b1110, 4'b0000, 1); gnt_is("R7 next starved", 2);

    // R9 wait states freeze
    sv_a = {aph_vld_o, dph_vld_o, 2'b00};
    sv_ai = int'(aph_id_o);
    cyc(4'b1111, 4'b0000, 0); gnt_is("R9 hold under wait", 2);
    cyc(4'b0001, 4'b0000, 0); gnt_is("R9 hold second wait", 2);
    chk("R9 stages frozen", int'({aph_vld_o, dph_vld_o, 2'b00}), int'(sv_a));
    chk("R9 aph id frozen", int'(aph_id_o), sv_ai);

    // R10 lock
    cyc(4'b0000, 4'b0000, 1);
    set_cfg(0, 0, 0, 3, 2, 15);
    cyc(4'b0010, 4'b0000, 1); gnt_is("R10 owner granted", 1);
    cyc(4'b1010, 4'b0010, 1); gnt_is("R10 locked 1", 1);
    cyc(4'b1010, 4'b0010, 1); gnt_is("R10 locked 2", 1);
    cyc(4'b1010, 4'b0010, 1); gnt_is("R10 locked 3", 1);
    cyc(4'b1010, 4'b0000, 1); gnt_is("R10 released", 3);

    // R11 pipeline of a lone request
    cyc(4'b0000, 4'b0000, 1);
    cyc(4'b0100, 4'b0000, 1); gnt_is("R11 grant stage", 2);
    cyc(4'b0100, 4'b0000, 1);
    chk("R11 aph valid", int'(aph_vld_o), 1);
    chk("R11 aph id", int'(aph_id_o), 2);
    cyc(4'b0000, 4'b0000, 1);
    chk("R11 dph valid", int'(dph_vld_o), 1);
    chk("R11 dph id", int'(dph_id_o), 2);
    chk("R11 aph empty", int'(aph_vld_o), 0);
    cyc(4'b0000, 4'b0000, 1);
    chk("R11 dph empty", int'(dph_vld_o), 0);

    // sweep: R3 R4 R5 R6 R7 R9 R10 against the model
    lf = 32'h1d87_2a43;
    for (int c = 0; c < 8; c++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      set_cfg(int'(lf[1:0]), int'(lf[3:2]), int'(lf[5:4]), int'(lf[7:6]), int'(lf[9:8]),
              (c == 0) ? 0 : (c == 1) ? 15 : int'(lf[13:10]));
      for (int t = 0; t < 400; t++) begin
        for (int s = 0; s < 7; s++) lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        cyc(lf[3:0], lf[3:0] & lf[7:4] & lf[11:8] & lf[15:12], lf[17:16] != 2'b00);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule